// File: doc/BRIEF.md
# Serial Register Access Controller

This block is a serial slave that gives an external controller read and write access to a small configuration register bank. The controller pulls chip select low, sends a 16-bit instruction (direction, byte count, start address) bit by bit on the serial clock, then moves data bytes. Writes are collected in a buffer bank. A self-clearing update command copies the whole buffer bank into the active bank in a single cycle, so a group of settings changes together. Reads return either the buffer or the active copy, as chosen by a readback select bit, and a read-only status byte taken from an input port.

The serial lines are sampled by the block's own system clock through synchronizers. SCLK must therefore run well below the system clock rate. A configuration register selects the bit order (most or least significant bit first), selects 3-wire or 4-wire read-out and holds a self-clearing soft reset. Short transfers may pause with chip select high on a byte boundary. Streaming transfers run until chip select rises.

Top module: `spi_reg_access`

## Requirements
- R1: A transaction starts when cs_ni falls. The first 16 bits, sampled on rising SCLK, form the instruction. In most-significant-first order these are: bit 15 direction (1 = read), bits 14:13 byte count (0..2 mean 1..3 bytes, 3 means streaming), bits 12:10 ignored, bits 9:0 the start address.
- R2: Written bytes change only the buffer bank. active_o keeps its value until an update.
- R3: Writing a byte with bit 0 set to address 0x232 copies every buffer register into its active register at once. That address always reads 0.
- R4: In most-significant-first mode the address decrements after each data byte.
- R5: Configuration bit 1 (address 0x000) selects least-significant-first order for the next transaction. In that order the instruction and the data bytes are bit-reversed, and the address increments after each byte.
- R6: In a 1 to 3 byte transfer, cs_ni may rise on a byte boundary and fall again to continue. Bits sent after the counted bytes, before cs_ni rises, are ignored. A streaming transfer moves bytes until cs_ni rises.
- R7: Read data changes on falling SCLK, so each bit is valid at the next rising edge. In 3-wire mode it appears on sdio_o with sdio_oe_o high. Both enables are low while chip select is high.
- R8: Configuration bit 2 selects 4-wire mode. Read data then appears on sdo_o with sdo_oe_o high, and sdio_oe_o stays low.
- R9: Readback bit 0 at address 0x004 selects the source of reads: 0 = buffer bank, 1 = active bank.
- R10: Writing configuration bit 0 returns both banks to their defaults (register i = 0xA0+i) and clears the configuration and readback registers. The bit reads back 0.
- R11: The general registers sit at 0x010 to 0x017 and status_i reads at 0x01F. Writes to the status address and to unmapped addresses are ignored, and unmapped reads return 0.
- R12: If cs_ni rises inside a byte, the transaction ends and the partial byte is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data into the block |
| sdio_o | output | 1 | Read data in 3-wire mode |
| sdio_oe_o | output | 1 | Drive enable for sdio_o |
| sdo_o | output | 1 | Read data in 4-wire mode |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| status_i | input | 8 | Read-only status byte |
| active_o | output | NUM_REGS*8 | Active register bank, register i at bits i*8+7:i*8 |

## Verification
Writes are given as single bytes, as 3-byte bursts with pauses between bytes and as 5-byte streams. Reading back each of them shows whether the byte counter and the direction of address stepping are right. The same transfers repeated in least-significant-first order show whether the bit order is applied to every field, since an instruction with the wrong order decodes to a different address. Reads from both banks before and after an update tell the buffer from the active copy. Aborted bytes, extra bytes after a short transfer, the high address bits, the read-only status address and unmapped addresses show that stray input leaves the bank unchanged.

// File: rtl/spi_reg_access_pkg.sv
package spi_reg_access_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_INSTR, ST_DATA, ST_DONE} xfer_st_e;

  localparam int          INSTR_BITS = 16;
  localparam logic [1:0]  CNT_STREAM = 2'd3;
  localparam int          CFG_SRST   = 0;
  localparam int          CFG_LSB    = 1;
  localparam int          CFG_4WIRE  = 2;

  function automatic logic [7:0] reg_default(input int idx);
    return 8'(8'hA0 + idx);
  endfunction
endpackage

// File: rtl/spi_reg_access_sync.sv
module spi_reg_access_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdio_i,
  output logic cs_o,
  output logic sdi_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] cs_q, sclk_q, sdi_q;
  logic         sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '1;
      sclk_q <= '0;
      sdi_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      cs_q   <= {cs_q[TOP-1:0], cs_ni};
      sclk_q <= {sclk_q[TOP-1:0], sclk_i};
      sdi_q  <= {sdi_q[TOP-1:0], sdio_i};
      sclk_d <= sclk_q[TOP];
    end
  end

  assign cs_o        = cs_q[TOP];
  assign sdi_o       = sdi_q[TOP];
  assign sclk_rise_o = sclk_q[TOP] & ~sclk_d;
  assign sclk_fall_o = ~sclk_q[TOP] & sclk_d;
endmodule

// File: rtl/spi_reg_access_engine.sv
module spi_reg_access_engine
  import spi_reg_access_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sdi_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              cfg_lsb_i,
  input  logic              cfg_4wire_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int BIT_W = $clog2(INSTR_BITS);

  xfer_st_e          st_q;
  logic [BIT_W-1:0]  bit_q;
  logic [15:0]       ish_q, ish_nxt;
  logic [7:0]        dsh_q, dsh_nxt, tx_q;
  logic              rw_q, lsb_q, out_q;
  logic [1:0]        cnt_q, nbyte_q;
  logic [ADDR_W-1:0] addr_q, step_addr;
  logic              byte_last, drive;

  always_comb begin
    ish_nxt   = lsb_q ? {sdi_i, ish_q[15:1]} : {ish_q[14:0], sdi_i};
    dsh_nxt   = lsb_q ? {sdi_i, dsh_q[7:1]}  : {dsh_q[6:0], sdi_i};
    step_addr = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
    rd_addr_o = (st_q == ST_INSTR) ? ish_nxt[ADDR_W-1:0] : step_addr;
    byte_last = (cnt_q != CNT_STREAM) && (nbyte_q == cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      ish_q     <= '0;
      dsh_q     <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      lsb_q     <= 1'b0;
      out_q     <= 1'b0;
      cnt_q     <= '0;
      nbyte_q   <= '0;
      addr_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (!cs_i) begin
          st_q  <= ST_INSTR;
          bit_q <= '0;
          lsb_q <= cfg_lsb_i;
        end
        ST_INSTR: begin
          if (cs_i) st_q <= ST_IDLE;
          else if (sclk_rise_i) begin
            ish_q <= ish_nxt;
            bit_q <= bit_q + 1'b1;
            if (bit_q == BIT_W'(INSTR_BITS - 1)) begin
              rw_q    <= ish_nxt[15];
              cnt_q   <= ish_nxt[14:13];
              addr_q  <= ish_nxt[ADDR_W-1:0];
              tx_q    <= rd_data_i;
              nbyte_q <= '0;
              bit_q   <= '0;
              st_q    <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (cs_i) begin
            // pause allowed only on a byte boundary of a short transfer
            if (bit_q != '0 || cnt_q == CNT_STREAM) st_q <= ST_IDLE;
          end else if (sclk_rise_i) begin
            dsh_q <= dsh_nxt;
            bit_q <= bit_q + 1'b1;
            if (bit_q == BIT_W'(7)) begin
              bit_q     <= '0;
              wr_en_o   <= !rw_q;
              wr_addr_o <= addr_q;
              wr_data_o <= dsh_nxt;
              addr_q    <= step_addr;
              tx_q      <= rd_data_i;
              if (byte_last) st_q <= ST_DONE;
              else if (cnt_q != CNT_STREAM) nbyte_q <= nbyte_q + 1'b1;
            end
          end else if (sclk_fall_i && rw_q) begin
            out_q <= lsb_q ? tx_q[bit_q[2:0]] : tx_q[3'd7 - bit_q[2:0]];
          end
        end
        ST_DONE: if (cs_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign drive     = !cs_i && rw_q && (st_q == ST_DATA);
  assign sdio_o    = out_q;
  assign sdo_o     = out_q;
  assign sdio_oe_o = drive && !cfg_4wire_i;
  assign sdo_oe_o  = drive && cfg_4wire_i;
endmodule

// File: rtl/spi_reg_access_regs.sv
module spi_reg_access_regs
  import spi_reg_access_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int ADDR_W    = 10,
  parameter int CFG_ADDR  = 'h000,
  parameter int RB_ADDR   = 'h004,
  parameter int GEN_BASE  = 'h010,
  parameter int STAT_ADDR = 'h01F,
  parameter int UPD_ADDR  = 'h232
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  input  logic [7:0]            status_i,
  output logic [7:0]            rd_data_o,
  output logic                  cfg_lsb_o,
  output logic                  cfg_4wire_o,
  output logic [NUM_REGS*8-1:0] active_o
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_RB   = ADDR_W'(RB_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_UPD  = ADDR_W'(UPD_ADDR);

  logic       soft_rst, upd, rb_act_q;
  logic [7:0] buf_q [NUM_REGS];
  logic [7:0] act_q [NUM_REGS];

  assign soft_rst = wr_en_i && wr_addr_i == A_CFG && wr_data_i[CFG_SRST];
  assign upd      = wr_en_i && wr_addr_i == A_UPD && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_lsb_o   <= 1'b0;
      cfg_4wire_o <= 1'b0;
      rb_act_q    <= 1'b0;
    end else if (soft_rst) begin
      cfg_lsb_o   <= 1'b0;
      cfg_4wire_o <= 1'b0;
      rb_act_q    <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CFG) begin
        cfg_lsb_o   <= wr_data_i[CFG_LSB];
        cfg_4wire_o <= wr_data_i[CFG_4WIRE];
      end
      if (wr_addr_i == A_RB) rb_act_q <= wr_data_i[0];
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(GEN_BASE + i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[i] <= reg_default(i);
        act_q[i] <= reg_default(i);
      end else if (soft_rst) begin
        buf_q[i] <= reg_default(i);
        act_q[i] <= reg_default(i);
      end else begin
        if (wr_en_i && wr_addr_i == MY_ADDR) buf_q[i] <= wr_data_i;
        if (upd) act_q[i] <= buf_q[i];
      end
    end
    assign active_o[i*8 +: 8] = act_q[i];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CFG)  rd_data_o = {5'b0, cfg_4wire_o, cfg_lsb_o, 1'b0};
    if (rd_addr_i == A_RB)   rd_data_o = {7'b0, rb_act_q};
    if (rd_addr_i == A_STAT) rd_data_o = status_i;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr_i == ADDR_W'(GEN_BASE + i)) rd_data_o = rb_act_q ? act_q[i] : buf_q[i];
    end
  end
endmodule

// File: rtl/spi_reg_access.sv
module spi_reg_access
  import spi_reg_access_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_ADDR    = 'h000,
  parameter int RB_ADDR     = 'h004,
  parameter int GEN_BASE    = 'h010,
  parameter int STAT_ADDR   = 'h01F,
  parameter int UPD_ADDR    = 'h232
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  sclk_i,
  input  logic                  sdio_i,
  output logic                  sdio_o,
  output logic                  sdio_oe_o,
  output logic                  sdo_o,
  output logic                  sdo_oe_o,
  input  logic [7:0]            status_i,
  output logic [NUM_REGS*8-1:0] active_o
);
  logic              cs_s, sdi_s, sclk_rise, sclk_fall;
  logic              cfg_lsb, cfg_4wire, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [7:0]        rd_data, wr_data;

  spi_reg_access_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdio_i,
    .cs_o(cs_s), .sdi_o(sdi_s), .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall)
  );

  spi_reg_access_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk_i, .rst_ni,
    .cs_i(cs_s), .sdi_i(sdi_s), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .cfg_lsb_i(cfg_lsb), .cfg_4wire_i(cfg_4wire),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sdio_o, .sdio_oe_o, .sdo_o, .sdo_oe_o
  );

  spi_reg_access_regs #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .RB_ADDR(RB_ADDR),
    .GEN_BASE(GEN_BASE), .STAT_ADDR(STAT_ADDR), .UPD_ADDR(UPD_ADDR)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .status_i, .rd_data_o(rd_data),
    .cfg_lsb_o(cfg_lsb), .cfg_4wire_o(cfg_4wire), .active_o
  );
endmodule

// File: rtl/spi_reg_access_chk.sv
module spi_reg_access_chk
  import spi_reg_access_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 10,
  parameter int CFG_ADDR = 'h000
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cs_s,
  input logic                  cfg_4wire,
  input logic                  sdio_oe_o,
  input logic                  sdo_oe_o,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [7:0]            wr_data,
  input logic [NUM_REGS*8-1:0] active_o
);
  logic [NUM_REGS*8-1:0] def_flat;
  always_comb for (int i = 0; i < NUM_REGS; i++) def_flat[i*8 +: 8] = reg_default(i);

  p_oe_off_cs_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |-> (!sdio_oe_o && !sdo_oe_o));

  p_sdio_quiet_4wire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_4wire |-> !sdio_oe_o);

  p_active_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(active_o));

  p_soft_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == ADDR_W'(CFG_ADDR) && wr_data[CFG_SRST]) |=> (active_o == def_flat));

  p_wr_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !wr_en);
endmodule

bind spi_reg_access spi_reg_access_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .cfg_4wire(cfg_4wire),
  .sdio_oe_o(sdio_oe_o), .sdo_oe_o(sdo_oe_o), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .active_o(active_o)
);

// File: tb/spi_reg_access_bench.sv
module spi_reg_access_bench;
  localparam int NUM_REGS = 8;
  localparam int HALF     = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdio = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [7:0] status = 8'h00;
  logic [NUM_REGS*8-1:0] active;

  int n_tests = 0, n_fail = 0;
  logic lsb_mode = 1'b0, four_wire = 1'b0;
  logic saw_sdio_oe = 1'b0, saw_sdo_oe = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #4 clk = ~clk;

  spi_reg_access u_spi_reg_access (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdio_i(sdio),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe),
    .status_i(status), .active_o(active)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] act_byte(input int i);
    return active[i*8 +: 8];
  endfunction

  task automatic spi_bit(input logic b, output logic r);
    sdio = b;
    tick(HALF);
    r = four_wire ? sdo_o : sdio_o;
    if (sdio_oe) saw_sdio_oe = 1'b1;
    if (sdo_oe) saw_sdo_oe = 1'b1;
    sclk = 1'b1;
    tick(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_instr(input logic rw, input int n, input logic [12:0] a);
    logic [15:0] w;
    logic r;
    w = {rw, (n > 3) ? 2'd3 : 2'(n - 1), a};
    for (int k = 0; k < 16; k++) spi_bit(lsb_mode ? w[k] : w[15-k], r);
  endtask

  task automatic xfer_byte(input logic [7:0] d, output logic [7:0] q);
    logic r;
    for (int k = 0; k < 8; k++) begin
      int idx = lsb_mode ? k : 7 - k;
      spi_bit(d[idx], r);
      q[idx] = r;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_off();
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic write_seq(input logic [12:0] a, input int n);
    logic [7:0] q;
    cs_on();
    send_instr(1'b0, n, a);
    for (int i = 0; i < n; i++) xfer_byte(wbuf[i], q);
    cs_off();
  endtask

  task automatic write1(input logic [12:0] a, input logic [7:0] d);
    wbuf[0] = d;
    write_seq(a, 1);
  endtask

  task automatic read_seq(input logic [12:0] a, input int n);
    cs_on();
    send_instr(1'b1, n, a);
    for (int i = 0; i < n; i++) xfer_byte(8'h00, rbuf[i]);
    cs_off();
  endtask

  task automatic t_reset();
    chk(act_byte(0), 8'hA0, "R10 default reg0");
    chk(act_byte(7), 8'hA7, "R10 default reg7");
    chk({6'b0, sdio_oe, sdo_oe}, 8'h00, "R7 outputs off at idle");
    read_seq(13'h000, 1);
    chk(rbuf[0], 8'h00, "R10 config reset value");
  endtask

  task automatic t_buffered();
    wbuf[0] = 8'h5A; wbuf[1] = 8'h3C;
    write_seq(13'h011, 2);
    chk(act_byte(1), 8'hA1, "R2 active reg1 held");
    chk(act_byte(0), 8'hA0, "R2 active reg0 held");
    saw_sdo_oe = 1'b0; saw_sdio_oe = 1'b0;
    read_seq(13'h011, 2);
    chk(rbuf[0], 8'h5A, "R4 buffer 0x011");
    chk(rbuf[1], 8'h3C, "R4 decremented 0x010");
    chk({6'b0, saw_sdio_oe, saw_sdo_oe}, 8'h02, "R7 3-wire drives sdio only");
    chk({6'b0, sdio_oe, sdo_oe}, 8'h00, "R7 off after cs high");
    write1(13'h004, 8'h01);
    read_seq(13'h011, 2);
    chk(rbuf[0], 8'hA1, "R9 active readback 0x011");
    chk(rbuf[1], 8'hA0, "R9 active readback 0x010");
    write1(13'h004, 8'h00);
  endtask

  task automatic t_update();
    write1(13'h232, 8'h01);
    chk(act_byte(1), 8'h5A, "R3 reg1 copied");
    chk(act_byte(0), 8'h3C, "R3 reg0 copied");
    chk(act_byte(2), 8'hA2, "R3 reg2 unchanged");
    read_seq(13'h232, 1);
    chk(rbuf[0], 8'h00, "R3 update bit self-clears");
  endtask

  task automatic t_lsb();
    write1(13'h000, 8'h02);
    lsb_mode = 1'b1;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h34;
    write_seq(13'h013, 3);
    write1(13'h232, 8'h01);
    chk(act_byte(3), 8'h11, "R5 lsb write 0x013");
    chk(act_byte(4), 8'h22, "R5 incremented 0x014");
    chk(act_byte(5), 8'h34, "R5 incremented 0x015");
    read_seq(13'h013, 3);
    chk(rbuf[0], 8'h11, "R5 lsb read 0x013");
    chk(rbuf[2], 8'h34, "R5 lsb read 0x015");
    read_seq(13'h000, 1);
    chk(rbuf[0], 8'h02, "R5 config lsb bit");
    write1(13'h000, 8'h00);
    lsb_mode = 1'b0;
  endtask

  task automatic t_pause();
    logic [7:0] q;
    cs_on();
    send_instr(1'b0, 3, 13'h017);
    xfer_byte(8'h71, q);
    cs_off(); cs_on();
    xfer_byte(8'h72, q);
    cs_off(); cs_on();
    xfer_byte(8'h73, q);
    xfer_byte(8'h99, q);
    cs_off();
    read_seq(13'h017, 3);
    chk(rbuf[0], 8'h71, "R6 paused byte 1");
    chk(rbuf[1], 8'h72, "R6 paused byte 2");
    chk(rbuf[2], 8'h73, "R6 paused byte 3");
    read_seq(13'h014, 1);
    chk(rbuf[0], 8'h22, "R6 extra byte ignored");
    for (int i = 0; i < 5; i++) wbuf[i] = 8'(8'h81 + i);
    write_seq(13'h017, 5);
    read_seq(13'h017, 5);
    chk(rbuf[0], 8'h81, "R6 stream first");
    chk(rbuf[4], 8'h85, "R6 stream fifth at 0x013");
  endtask

  task automatic t_abort();
    logic r;
    cs_on();
    send_instr(1'b0, 1, 13'h010);
    for (int k = 0; k < 4; k++) spi_bit(1'b1, r);
    cs_off();
    read_seq(13'h010, 1);
    chk(rbuf[0], 8'h3C, "R12 partial byte dropped");
  endtask

  task automatic t_4wire();
    write1(13'h000, 8'h04);
    four_wire = 1'b1;
    status = 8'h96;
    saw_sdo_oe = 1'b0; saw_sdio_oe = 1'b0;
    read_seq(13'h01F, 1);
    chk(rbuf[0], 8'h96, "R8 status on sdo");
    chk({6'b0, saw_sdio_oe, saw_sdo_oe}, 8'h01, "R8 sdo drives, sdio quiet");
    write1(13'h000, 8'h00);
    four_wire = 1'b0;
  endtask

  task automatic t_addr();
    write1(13'h0FF, 8'h77);
    read_seq(13'h0FF, 1);
    chk(rbuf[0], 8'h00, "R11 unmapped read zero");
    write1(13'h1C12, 8'h5E);
    read_seq(13'h012, 1);
    chk(rbuf[0], 8'h5E, "R1 high address bits ignored");
    write1(13'h01F, 8'h00);
    read_seq(13'h01F, 1);
    chk(rbuf[0], 8'h96, "R11 status read-only");
  endtask

  task automatic t_srst();
    write1(13'h004, 8'h01);
    write1(13'h000, 8'h01);
    chk(act_byte(0), 8'hA0, "R10 soft reset reg0");
    chk(act_byte(3), 8'hA3, "R10 soft reset reg3");
    read_seq(13'h012, 1);
    chk(rbuf[0], 8'hA2, "R10 buffer default");
    read_seq(13'h004, 1);
    chk(rbuf[0], 8'h00, "R10 readback select cleared");
    read_seq(13'h000, 1);
    chk(rbuf[0], 8'h00, "R10 reset bit self-clears");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_buffered();
    t_update();
    t_lsb();
    t_pause();
    t_abort();
    t_4wire();
    t_addr();
    t_srst();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule